// File: doc/BRIEF.md
# Hardware Address Breakpoint Controller

This block watches the CPU address bus and asks for a break when a qualified address equals a programmed 16-bit breakpoint. The breakpoint is held as a high byte and a low byte, each compared by its own byte comparator. The break does not start at once. The request is held until the CPU reports an instruction boundary, and then the block enters a break state. The break state lasts until the CPU reports a return-from-interrupt.

Software can also force a break by writing the active bit. A sticky flag records that a break woke the CPU from stop or wait. A flag-clear enable decides whether status clears are honoured while the break state is active.

While in the break state, the block freezes a timer. It also disables a watchdog, but only when a high-voltage reset indication is present. A vector hint tells the CPU core which handler base to fetch: one for normal mode, one for monitor mode.

Top module: `brkpt_ctrl`

## Requirements
- R1: After reset, every register reads 0 and brk_req, in_break, timer_freeze and wdog_disable are 0.
- R2: Register offsets are fixed as follows, and a write of 0xFF followed by a read returns the value shown.
  - 0x0C is the breakpoint high byte and reads back 0xFF.
  - 0x0D is the breakpoint low byte and reads back 0xFF.
  - 0x03 holds the flag-clear enable in bit 7 and reads back 0x80.
  - 0x0E holds the enable in bit 7 and the active bit in bit 6; writing 0x80 to it reads back 0x80.
  - 0x00 holds the wake flag in bit 1 and reads back 0x00, because writing 1 there has no effect.
  - Any other offset reads 0.
- R3: A request arises only when cpu_addr_vld is 1 and all 16 address bits equal the breakpoint. A single differing bit, or a low strobe, gives no request. brk_req rises in the cycle after the strobed address.
- R4: With the enable bit at 0, a matching address gives no request.
- R5: A request is held until a cycle in which instr_done is 1, and the break state begins at that clock edge. If instr_done is 1 in the first cycle of the request, entry is immediate.
- R6: A hardware match sets the active bit. Writing 0 to bit 6 of 0x0E clears it.
- R7: Outside the break state, writing 1 to bit 6 of 0x0E raises brk_req in the next cycle.
- R8: When rti_exec is 1 while in the break state, the break state ends at the next edge.
- R9: vec_base is 0xFFFC when monitor_mode is 0 and 0xFEFC when monitor_mode is 1.
- R10: timer_freeze equals the break state. wdog_disable is 1 only in the break state with hv_on_reset at 1.
- R11: Entering the break state while low_power is 1 sets the wake flag. Writing 0 to bit 1 of 0x00 outside the break state clears it.
- R12: status_clr_ok is 0 in the break state while the flag-clear enable is 0. In that condition, a write of 0 to the wake flag leaves it set.
- R13: A write to 0x0E in the same cycle as a hardware set of the active bit wins over the hardware set.
- R14: Address matches and forced breaks during the break state raise no request, either during the break or after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational, free of side effects |
| cpu_addr | input | 16 | CPU address bus |
| cpu_addr_vld | input | 1 | Address strobe qualifying cpu_addr |
| instr_done | input | 1 | Current instruction completes this cycle |
| rti_exec | input | 1 | Return-from-interrupt executed |
| low_power | input | 1 | CPU is in stop or wait |
| monitor_mode | input | 1 | Monitor mode selects the alternate vector |
| hv_on_reset | input | 1 | High voltage present on the reset pin |
| brk_req | output | 1 | Pending break request |
| in_break | output | 1 | Break state active |
| vec_base | output | 16 | Break vector base address hint |
| timer_freeze | output | 1 | Freezes the timer counter |
| wdog_disable | output | 1 | Disables the watchdog |
| status_clr_ok | output | 1 | Status clears honoured |

## Verification
Every cycle, the assertions check the following:
- The break state only begins on an edge where a request meets an instruction boundary.
- A request without a boundary persists.
- A return-from-interrupt ends the break.
- No request coexists with the break state.
- The watchdog disable never appears without the timer freeze.
- The wake flag survives while clears are blocked.

Only the bench's scenarios can show the rest:
- The exact comparison across all sixteen single-bit mismatches.
- The register map and masking.
- Software-forced breaks.
- The write-over-hardware priority.
- The vector choice.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;
  localparam logic [3:0] OFS_WAKE = 4'h0;
  localparam logic [3:0] OFS_FCE  = 4'h3;
  localparam logic [3:0] OFS_AHI  = 4'hC;
  localparam logic [3:0] OFS_ALO  = 4'hD;
  localparam logic [3:0] OFS_CTL  = 4'hE;

  localparam logic [15:0] VEC_NORMAL  = 16'hFFFC;
  localparam logic [15:0] VEC_MONITOR = 16'hFEFC;

  function automatic logic [15:0] pick_vector(input logic mon);
    return mon ? VEC_MONITOR : VEC_NORMAL;
  endfunction

  function automatic logic clear_allowed(input logic brk, input logic fce);
    return !brk || fce;
  endfunction
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bp_addr,
  input  logic              enable,
  input  logic              blocked,
  output logic              hit_q
);
  localparam int NB = ADDR_W / BYTE_W;
  logic [NB-1:0] byte_eq;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_eq[b] = (bus_addr[b*BYTE_W +: BYTE_W] == bp_addr[b*BYTE_W +: BYTE_W]);
  end

  logic hit_d;
  assign hit_d = enable && bus_vld && !blocked && (&byte_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              hw_hit,
  input  logic              enter_evt,
  input  logic              low_power,
  input  logic              clr_ok,
  output logic [ADDR_W-1:0] bp_addr,
  output logic              enable,
  output logic              active,
  output logic              fce,
  output logic              wake,
  output logic              sw_force
);
  localparam int NB = ADDR_W / BYTE_W;

  logic wr_ctl, wr_fce, wr_wake;
  assign wr_ctl  = wr && (addr == OFS_CTL);
  assign wr_fce  = wr && (addr == OFS_FCE);
  assign wr_wake = wr && (addr == OFS_WAKE);
  assign sw_force = wr_ctl && wdata[6];

  for (genvar b = 0; b < NB; b++) begin : g_bp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bp_addr[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr && (addr == OFS_ALO - 4'(b)))
        bp_addr[b*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      active <= 1'b0;
      fce    <= 1'b0;
      wake   <= 1'b0;
    end else begin
      if (wr_ctl) begin
        enable <= wdata[7];
        active <= wdata[6];
      end else if (hw_hit) begin
        active <= 1'b1;
      end
      if (wr_fce) fce <= wdata[7];
      if (wr_wake && !wdata[1] && clr_ok) wake <= 1'b0;
      else if (enter_evt && low_power)    wake <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_WAKE: rdata[1]   = wake;
      OFS_FCE:  rdata[7]   = fce;
      OFS_CTL:  rdata[7:6] = {enable, active};
      default:  rdata      = '0;
    endcase
    for (int b = 0; b < NB; b++)
      if (addr == OFS_ALO - 4'(b)) rdata = bp_addr[b*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/brk_seq.sv
module brk_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_q,
  input  logic sw_force,
  input  logic instr_done,
  input  logic rti_exec,
  output logic req,
  output logic enter_evt,
  output logic in_brk
);
  logic pend_q;

  assign req       = (hit_q || pend_q) && !in_brk;
  assign enter_evt = req && instr_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      in_brk <= 1'b0;
    end else begin
      if (enter_evt) pend_q <= 1'b0;
      else if ((hit_q || sw_force) && !in_brk) pend_q <= 1'b1;
      if (in_brk && rti_exec) in_brk <= 1'b0;
      else if (enter_evt)     in_brk <= 1'b1;
    end
  end
endmodule

// File: rtl/brkpt_ctrl.sv
module brkpt_ctrl
  import brkpt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_addr_vld,
  input  logic              instr_done,
  input  logic              rti_exec,
  input  logic              low_power,
  input  logic              monitor_mode,
  input  logic              hv_on_reset,
  output logic              brk_req,
  output logic              in_break,
  output logic [15:0]       vec_base,
  output logic              timer_freeze,
  output logic              wdog_disable,
  output logic              status_clr_ok
);
  logic [ADDR_W-1:0] bp_addr;
  logic enable, active, fce, wake, sw_force;
  logic hit_q, enter_evt;

  assign status_clr_ok = clear_allowed(in_break, fce);

  brk_regs #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .hw_hit(hit_q), .enter_evt(enter_evt), .low_power(low_power),
    .clr_ok(status_clr_ok), .bp_addr(bp_addr), .enable(enable), .active(active),
    .fce(fce), .wake(wake), .sw_force(sw_force)
  );

  brk_cmp #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .bus_addr(cpu_addr), .bus_vld(cpu_addr_vld),
    .bp_addr(bp_addr), .enable(enable), .blocked(in_break), .hit_q(hit_q)
  );

  brk_seq u_seq (
    .clk(clk), .rst_n(rst_n), .hit_q(hit_q), .sw_force(sw_force),
    .instr_done(instr_done), .rti_exec(rti_exec), .req(brk_req),
    .enter_evt(enter_evt), .in_brk(in_break)
  );

  assign vec_base     = pick_vector(monitor_mode);
  assign timer_freeze = in_break;
  assign wdog_disable = in_break && hv_on_reset;
endmodule

// File: rtl/brkpt_ctrl_chk.sv
module brkpt_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic brk_req,
  input logic instr_done,
  input logic in_break,
  input logic rti_exec,
  input logic timer_freeze,
  input logic wdog_disable,
  input logic hv_on_reset,
  input logic wake,
  input logic fce
);
  AST_ENTRY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_break) |-> $past(brk_req && instr_done)); // R5
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && !instr_done |=> brk_req); // R5
  AST_RTI_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    in_break && rti_exec |=> !in_break); // R8
  AST_WDOG_NEEDS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_disable |-> timer_freeze && hv_on_reset); // R10
  AST_NO_REQ_IN_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    in_break |-> !brk_req); // R14
  AST_WAKE_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    wake && in_break && !fce |=> wake); // R12
endmodule

bind brkpt_ctrl brkpt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .instr_done(instr_done),
  .in_break(in_break), .rti_exec(rti_exec), .timer_freeze(timer_freeze),
  .wdog_disable(wdog_disable), .hv_on_reset(hv_on_reset), .wake(wake), .fce(fce)
);

// File: tb/brkpt_ctrl_tb.sv
module brkpt_ctrl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0; logic [3:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [15:0] cpu_addr = 0; logic cpu_addr_vld = 0;
  logic instr_done = 0, rti_exec = 0, low_power = 0, monitor_mode = 0, hv_on_reset = 0;
  logic brk_req, in_break, timer_freeze, wdog_disable, status_clr_ok;
  logic [15:0] vec_base;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  localparam logic [15:0] BP = 16'h1234;

  always #4 clk = ~clk;

  brkpt_ctrl u_dut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask
  task automatic step(); @(negedge clk); endtask
  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step(); reg_wr = 0;
  endtask
  task automatic rd_chk(string tag, logic [3:0] a, logic [7:0] exp);
    reg_addr = a; #1; chk(tag, 16'(reg_rdata), 16'(exp));
  endtask
  task automatic present(logic [15:0] a, logic v);
    cpu_addr = a; cpu_addr_vld = v; step(); cpu_addr_vld = 0;
  endtask
  task automatic boundary(); instr_done = 1; step(); instr_done = 0; endtask
  task automatic do_rti(); rti_exec = 1; step(); rti_exec = 0; endtask
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R1 reset state
    foreach (u_dut.reg_rdata[i]) ;
    for (int a = 0; a < 16; a++) rd_chk("R1 reg", 4'(a), 8'h00);
    chk("R1 outputs", {12'h0, brk_req, in_break, timer_freeze, wdog_disable}, 16'h0);
    // R2 map and masking
    wr(4'h0, 8'hFF); rd_chk("R2 wake", 4'h0, 8'h00);
    wr(4'h3, 8'hFF); rd_chk("R2 fce", 4'h3, 8'h80);
    wr(4'hC, 8'hFF); rd_chk("R2 hi", 4'hC, 8'hFF);
    wr(4'hD, 8'hFF); rd_chk("R2 lo", 4'hD, 8'hFF);
    wr(4'hE, 8'h80); rd_chk("R2 ctl", 4'hE, 8'h80);
    wr(4'h5, 8'hFF); rd_chk("R2 unmapped", 4'h5, 8'h00);
    wr(4'hE, 8'h00); wr(4'h3, 8'h00);
    wr(4'hC, BP[15:8]); wr(4'hD, BP[7:0]);
    // R4 disabled
    present(BP, 1); chk("R4 disabled", 16'(brk_req), 16'h0);
    // R3 exact compare sweep
    wr(4'hE, 8'h80);
    for (int i = 0; i < 16; i++) begin
      present(BP ^ (16'h1 << i), 1); chk("R3 one-bit mismatch", 16'(brk_req), 16'h0);
    end
    present(BP, 0); chk("R3 no strobe", 16'(brk_req), 16'h0);
    present(BP, 1); chk("R3 match", 16'(brk_req), 16'h1);
    // R5 held request, R6 active set
    for (int i = 0; i < 3; i++) begin
      step(); chk("R5 held", 16'(brk_req), 16'h1);
    end
    rd_chk("R6 active set", 4'hE, 8'hC0);
    chk("R5 not yet", 16'(in_break), 16'h0);
    boundary();
    chk("R5 entered", {brk_req, in_break}, 16'h1);
    chk("R10 freeze", {timer_freeze, wdog_disable}, 16'h2);
    hv_on_reset = 1; #1; chk("R10 wdog", {timer_freeze, wdog_disable}, 16'h3);
    monitor_mode = 0; #1; chk("R9 normal", vec_base, 16'hFFFC);
    monitor_mode = 1; #1; chk("R9 monitor", vec_base, 16'hFEFC);
    // R14 matches and forces in break
    present(BP, 1); chk("R14 in break", 16'(brk_req), 16'h0);
    wr(4'hE, 8'hC0); chk("R14 force in break", 16'(brk_req), 16'h0);
    do_rti(); chk("R8 exit", 16'(in_break), 16'h0);
    chk("R10 off", {timer_freeze, wdog_disable}, 16'h0);
    step(); chk("R14 after exit", 16'(brk_req), 16'h0);
    wr(4'hE, 8'h80); rd_chk("R6 active cleared", 4'hE, 8'h80);
    // R5 immediate entry, R11 wake, R12 guard
    low_power = 1;
    cpu_addr = BP; cpu_addr_vld = 1; step(); cpu_addr_vld = 0;
    chk("R5 first cycle req", 16'(brk_req), 16'h1);
    boundary(); low_power = 0;
    chk("R5 immediate", 16'(in_break), 16'h1);
    rd_chk("R11 wake set", 4'h0, 8'h02);
    chk("R12 clr blocked", 16'(status_clr_ok), 16'h0);
    wr(4'h0, 8'h00); rd_chk("R12 wake kept", 4'h0, 8'h02);
    wr(4'h3, 8'h80); chk("R12 clr allowed", 16'(status_clr_ok), 16'h1);
    wr(4'h0, 8'h00); rd_chk("R12 wake cleared", 4'h0, 8'h00);
    do_rti(); wr(4'h3, 8'h00);
    // R7 software force
    wr(4'hE, 8'hC0); chk("R7 forced", 16'(brk_req), 16'h1);
    low_power = 1; boundary(); low_power = 0;
    chk("R7 entered", 16'(in_break), 16'h1);
    do_rti();
    wr(4'h0, 8'h00); rd_chk("R11 clear outside", 4'h0, 8'h00);
    wr(4'hE, 8'h80);
    // R13 write wins over hardware set
    cpu_addr = BP; cpu_addr_vld = 1; step(); cpu_addr_vld = 0;
    wr(4'hE, 8'h80);
    rd_chk("R13 write wins", 4'hE, 8'h80);
    boundary(); do_rti();
    finish_run();
  end
endmodule